// File: doc/BRIEF.md
# Latched-Address Inverting 1-of-16 Decoder

This block turns a binary address into one active-low select line out of sixteen. Its address path has a hold stage. While the hold-enable input is high, the address inputs pass straight through to the decoder. While it is low, the decoder works from the address it last took in. A separate active-low output enable gates only the sixteen lines. It never disturbs the held address, so a stored address can be strobed repeatedly.

The same gating makes the block a 1-to-16 demultiplexer. A serial data bit is driven on the output enable. The addressed line then repeats that bit, and every other line stays high. The design is fully synchronous and FPGA-friendly. The hold stage is a clock-enabled register that updates on every clock edge where the hold-enable input is high. The sixteen outputs are registered, so every input change shows at the outputs one clock later. The width of the address is a parameter, and the number of outputs follows from it.

Top module: `latched_line_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `held_addr` becomes 0 and all outputs `sel_n` become 1 at that edge.
- R2: With `en_n` low and `hold_en` high, one clock after the address is applied, `sel_n[k]` is 0 where k is the unsigned value of `addr_in` (bit 0 least significant), and every other bit of `sel_n` is 1.
- R3: With `hold_en` low, `held_addr` keeps its value and `sel_n` does not respond to changes on `addr_in`. The selected line stays the one chosen by the last address taken in while `hold_en` was high.
- R4: With `en_n` high, all bits of `sel_n` are 1 one clock later, whatever the address or the state of the hold stage.
- R5: `en_n` has no effect on `held_addr`. The hold stage captures and holds the same way whether the outputs are enabled or disabled.
- R6: At no time after reset is more than one bit of `sel_n` low.
- R7: Demultiplexing: with `hold_en` low, the line indexed by `held_addr` carries the value that `en_n` had one clock earlier, and all other lines are 1.
- R8: At each clock edge where `hold_en` is high, `held_addr` takes the value of `addr_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W (4) | Binary address, bit 0 least significant |
| hold_en | input | 1 | High: address passes through; low: hold the stored address |
| en_n | input | 1 | Active-low output enable; acts as the data input in demultiplexer use |
| sel_n | output | 2**ADDR_W (16) | Registered active-low select lines |
| held_addr | output | ADDR_W (4) | Currently stored address, for observation |

## Verification
The bench builds the block with its default `ADDR_W` of 4. All sixteen lines are therefore driven and each one is checked, including the extreme indices 0 and 15. Because the stored address is brought out on `held_addr`, the bench can show directly that `en_n` never disturbs the stored value. It does this both while the hold stage is capturing and while it is holding. At the same width, the bench runs demultiplexing on a fixed held index with a mixed data pattern.

// File: rtl/latched_dec_pkg.sv
package latched_dec_pkg;
  function automatic int unsigned line_count(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] held,
  output logic [ADDR_W-1:0] eff_addr
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (hold_en) held <= addr_in;
  end

  // transparent path while hold_en is high
  always_comb eff_addr = hold_en ? addr_in : held;

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !hold_en |=> $stable(held));
  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    hold_en |=> held == $past(addr_in));
endmodule

// File: rtl/line_decode.sv
module line_decode #(
  parameter int ADDR_W = 4,
  localparam int LINES = latched_dec_pkg::line_count(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LINES-1:0]  hot
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = (addr == ADDR_W'(i));
  end

  always_comb assert_hot_R2: assert ($onehot(hot));
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int ADDR_W = 4,
  localparam int LINES = latched_dec_pkg::line_count(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  hot,
  output logic [LINES-1:0]  sel_n
);
  always_ff @(posedge clk) begin
    if (rst)       sel_n <= '1;
    else if (en_n) sel_n <= '1;
    else           sel_n <= ~hot;
  end

  assert_one_low_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));
  assert_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    en_n |=> &sel_n);
  assert_selected_R2: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> !sel_n[$past(addr)]);
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
  parameter int ADDR_W = 4,
  localparam int LINES = latched_dec_pkg::line_count(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              hold_en,
  input  logic              en_n,
  output logic [LINES-1:0]  sel_n,
  output logic [ADDR_W-1:0] held_addr
);
  logic [ADDR_W-1:0] eff_addr;
  logic [LINES-1:0]  hot;

  addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .hold_en(hold_en), .addr_in(addr_in),
    .held(held_addr), .eff_addr(eff_addr)
  );

  line_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(eff_addr), .hot(hot));

  out_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst(rst), .en_n(en_n), .addr(eff_addr), .hot(hot), .sel_n(sel_n)
  );

  assert_en_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!hold_en && $changed(en_n)) |=> $stable(held_addr));
  assert_demux_R7: assert property (@(posedge clk) disable iff (rst)
    !hold_en |=> sel_n[held_addr] == $past(en_n));
endmodule

// File: tb/latched_line_decoder_test.sv
module latched_line_decoder_test;
  localparam int AW = 4;
  localparam int N  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          hold_en = 1'b0;
  logic          en_n = 1'b1;
  logic [N-1:0]  sel_n;
  logic [AW-1:0] held_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  latched_line_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .hold_en(hold_en),
    .en_n(en_n), .sel_n(sel_n), .held_addr(held_addr)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk_out(string req, logic [N-1:0] exp);
    tests++;
    if (sel_n !== exp) begin
      fails++;
      $display("FAIL %s sel_n actual=%h expected=%h", req, sel_n, exp);
    end
  endtask

  task automatic chk_held(string req, logic [AW-1:0] exp);
    tests++;
    if (held_addr !== exp) begin
      fails++;
      $display("FAIL %s held_addr actual=%0d expected=%0d", req, held_addr, exp);
    end
  endtask

  task automatic t_reset();
    hold_en = 1; en_n = 0; addr_in = 4'd7;
    tick();
    chk_out("R1", '1);
    chk_held("R1", 4'd0);
    rst = 0;
  endtask

  task automatic t_sweep();
    hold_en = 1; en_n = 0;
    for (int a = 0; a < N; a++) begin
      addr_in = AW'(a);
      tick();
      chk_out("R2", ~(N'(1) << a));
      chk_held("R8", AW'(a));
    end
    for (int a = N - 1; a >= 0; a -= 5) begin
      addr_in = AW'(a);
      tick();
      chk_out("R6", ~(N'(1) << a));
    end
  endtask

  task automatic t_hold();
    hold_en = 1; en_n = 0; addr_in = 4'd9;
    tick();
    hold_en = 0;
    for (int k = 0; k < 4; k++) begin
      addr_in = AW'(3 + 4 * k);
      tick();
      chk_out("R3", ~(N'(1) << 9));
      chk_held("R3", 4'd9);
    end
  endtask

  task automatic t_disable();
    hold_en = 0; en_n = 1; addr_in = 4'd0;
    tick();
    chk_out("R4", '1);
    hold_en = 1; addr_in = 4'd5;
    tick();
    chk_out("R4", '1);
    chk_held("R5", 4'd5);
    hold_en = 0; addr_in = 4'd2;
    en_n = 0; tick(); chk_held("R5", 4'd5); chk_out("R5", ~(N'(1) << 5));
    en_n = 1; tick(); chk_held("R5", 4'd5); chk_out("R4", '1);
  endtask

  task automatic t_demux();
    logic [7:0] pat = 8'b1011_0010;
    hold_en = 1; en_n = 1; addr_in = 4'd15;
    tick();
    hold_en = 0; addr_in = 4'd1;
    for (int b = 0; b < 8; b++) begin
      en_n = pat[b];
      tick();
      chk_out("R7", pat[b] ? '1 : ~(N'(1) << 15));
    end
    chk_held("R7", 4'd15);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_disable();
    t_demux();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule